// File: doc/BRIEF.md
# Dual-Port Pixel Byte Formatter

This block takes a stream of pixel bytes and spreads it over two output byte ports, A and B. In single-channel arrangement every accepted byte goes to port A one clock after it is accepted, and port B stays at zero. In dual-channel arrangement consecutive bytes of a line alternate between the two ports, so each port carries half the byte rate. Dual-channel output has two timings. In staggered timing each byte leaves on its own port on the clock after it arrives, so the two ports update on alternate beats. In paired timing the block holds the first byte of each pair and updates both ports together when the second byte arrives.

A start-of-line flag marks the first byte of every line. With that byte the block captures its three configuration inputs: arrangement, timing, and which port takes the first byte. It also restarts the port alternation. A half-rate data clock output marks whether the byte just presented had an even index in its line.

The input is a valid/ready stream. `in_ready` is always high, so the block never applies back-pressure: a byte is accepted on every clock where `in_valid` is high. The outputs cannot be stalled. Each port has a one-clock strobe that marks the clock on which its byte is new.

Top module: `pix_dual_port_fmt`

## Requirements
- R1: After reset, both port bytes, both strobes and `dclk_out` are zero.
- R2: In single-channel arrangement (`cfg_dual`=0), each accepted byte appears on `a_data` with `a_valid` high on the next clock. On that clock `b_data` is zero and `b_valid` is low.
- R3: In staggered dual timing (`cfg_dual`=1, `cfg_parallel`=0), each accepted byte appears on the next clock on exactly one port, with only that port's strobe high. Consecutive bytes of a line go to opposite ports.
- R4: Byte index 0 of a line (the byte carrying `in_sol`) goes to port A when `cfg_a_first`=1 and to port B when it is 0. Even-indexed bytes follow byte 0 and odd-indexed bytes take the other port. The index restarts at 0 on every line.
- R5: In paired dual timing (`cfg_parallel`=1), accepting an even-indexed byte raises no strobe. Accepting the next odd-indexed byte updates both ports on the following clock with both strobes high. The even byte goes to the port chosen by R4 and the odd byte goes to the other port.
- R6: The three configuration inputs are sampled only on an accepted byte with `in_sol` high. Changes at any other time do not affect the line in progress.
- R7: After each accepted byte in dual arrangement, `dclk_out` is 1 if the byte index was even and 0 if it was odd. In single arrangement it is 0. It holds its value while no byte is accepted.
- R8: On a clock after no byte was accepted, both strobes are low and both port bytes keep their values.
- R9: In paired timing, an unpaired final byte of a line is dropped when the next line starts. No strobe is raised for it.
- R10: `in_ready` is high at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dual | input | 1 | 0 single-channel, 1 dual-channel arrangement |
| cfg_parallel | input | 1 | Dual timing: 0 staggered, 1 paired |
| cfg_a_first | input | 1 | First byte of a line to port: 0 B, 1 A |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Always high; no back-pressure |
| in_data | input | DATA_W | Input pixel byte |
| in_sol | input | 1 | Marks the first byte of a line |
| a_data | output | DATA_W | Port A byte |
| a_valid | output | 1 | Port A byte is new this clock |
| b_data | output | DATA_W | Port B byte |
| b_valid | output | 1 | Port B byte is new this clock |
| dclk_out | output | 1 | Half-rate data clock (even-index marker) |

## Verification
The assertions check on every cycle the properties that a single beat fixes. Single arrangement clears port B and leaves its strobe low. Staggered timing raises exactly one strobe. Paired timing raises both strobes on an odd beat and none on an even beat, and an odd beat always finds a held partner. An idle clock raises no strobe, and the captured configuration moves only on a start-of-line beat. Only the bench's scenarios can show the rest. Those are the byte values on each port and the phase choice across successive lines. They also cover configuration changes in the middle of a line being ignored, the unpaired byte dropped at a line boundary, and the data clock following the byte index through gaps in `in_valid`.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef struct packed {
    logic dual;
    logic par;
    logic a_first;
  } fmt_mode_t;

  localparam fmt_mode_t FMT_MODE_RESET = '{dual: 1'b0, par: 1'b0, a_first: 1'b0};
endpackage

// File: rtl/fmt_mode_latch.sv
module fmt_mode_latch
  import fmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      beat,
  input  logic      sol,
  input  fmt_mode_t cfg,
  output fmt_mode_t mode_eff
);
  fmt_mode_t held_q;
  logic      take;

  assign take     = beat && sol;
  assign mode_eff = take ? cfg : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= FMT_MODE_RESET;
    else if (take) held_q <= cfg;
  end

  // R6: configuration moves only on a start-of-line beat
  assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (held_q == $past(held_q)));
endmodule

// File: rtl/fmt_lane_steer.sv
module fmt_lane_steer
  import fmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      beat,
  input  logic      sol,
  input  fmt_mode_t mode,
  output logic      cur_odd,
  output logic      to_a
);
  logic next_odd_q;

  assign cur_odd = sol ? 1'b0 : next_odd_q;
  // even-indexed bytes go to the first port, odd ones to the other
  assign to_a    = !mode.dual || ((!cur_odd) == mode.a_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    next_odd_q <= 1'b0;
    else if (beat) next_odd_q <= !cur_odd;
  end

  // R4: a start-of-line byte is always index 0
  assert_sol_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sol) |=> !$past(cur_odd));
endmodule

// File: rtl/fmt_port_regs.sv
module fmt_port_regs
  import fmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [DATA_W-1:0] data,
  input  fmt_mode_t         mode,
  input  logic              cur_odd,
  input  logic              to_a,
  output logic [DATA_W-1:0] a_data,
  output logic              a_valid,
  output logic [DATA_W-1:0] b_data,
  output logic              b_valid,
  output logic              dclk
);
  logic [DATA_W-1:0] hold_q;
  logic              hold_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_data   <= '0;
      b_data   <= '0;
      a_valid  <= 1'b0;
      b_valid  <= 1'b0;
      dclk     <= 1'b0;
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else begin
      a_valid <= 1'b0;
      b_valid <= 1'b0;
      if (beat) begin
        if (!mode.dual) begin
          a_data   <= data;
          a_valid  <= 1'b1;
          b_data   <= '0;
          dclk     <= 1'b0;
          hold_v_q <= 1'b0;
        end else if (!mode.par) begin
          dclk     <= !cur_odd;
          hold_v_q <= 1'b0;
          if (to_a) begin
            a_data  <= data;
            a_valid <= 1'b1;
          end else begin
            b_data  <= data;
            b_valid <= 1'b1;
          end
        end else begin
          dclk <= !cur_odd;
          if (!cur_odd) begin
            hold_q   <= data;
            hold_v_q <= 1'b1;
          end else begin
            a_data   <= mode.a_first ? hold_q : data;
            b_data   <= mode.a_first ? data : hold_q;
            a_valid  <= 1'b1;
            b_valid  <= 1'b1;
            hold_v_q <= 1'b0;
          end
        end
      end
    end
  end

  assert_single_b_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !mode.dual) |=> (b_data == '0 && !b_valid && a_valid));
  assert_stagger_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && mode.dual && !mode.par) |=> ($countones({a_valid, b_valid}) == 1));
  assert_pair_both_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && mode.dual && mode.par && cur_odd) |=> (a_valid && b_valid));
  assert_pair_even_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && mode.dual && mode.par && !cur_odd) |=> (!a_valid && !b_valid));
  assert_pair_has_partner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && mode.dual && mode.par && cur_odd) |-> hold_v_q);
  assert_idle_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> (!a_valid && !b_valid && $stable(a_data) && $stable(b_data)));
endmodule

// File: rtl/pix_dual_port_fmt.sv
module pix_dual_port_fmt
  import fmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dual,
  input  logic              cfg_parallel,
  input  logic              cfg_a_first,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sol,
  output logic [DATA_W-1:0] a_data,
  output logic              a_valid,
  output logic [DATA_W-1:0] b_data,
  output logic              b_valid,
  output logic              dclk_out
);
  fmt_mode_t cfg_w;
  fmt_mode_t mode_w;
  logic      beat;
  logic      cur_odd;
  logic      to_a;

  assign in_ready = 1'b1;
  assign beat     = in_valid && in_ready;
  assign cfg_w    = '{dual: cfg_dual, par: cfg_parallel, a_first: cfg_a_first};

  fmt_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sol(in_sol),
    .cfg(cfg_w), .mode_eff(mode_w)
  );

  fmt_lane_steer u_steer (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sol(in_sol),
    .mode(mode_w), .cur_odd(cur_odd), .to_a(to_a)
  );

  fmt_port_regs #(.DATA_W(DATA_W)) u_ports (
    .clk(clk), .rst_n(rst_n), .beat(beat), .data(in_data),
    .mode(mode_w), .cur_odd(cur_odd), .to_a(to_a),
    .a_data(a_data), .a_valid(a_valid), .b_data(b_data),
    .b_valid(b_valid), .dclk(dclk_out)
  );
endmodule

// File: tb/tb_pix_dual_port_fmt.sv
module tb_pix_dual_port_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_dual = 0, cfg_parallel = 0, cfg_a_first = 0;
  logic       in_valid = 0, in_sol = 0;
  logic [7:0] in_data = '0;
  logic       in_ready, a_valid, b_valid, dclk_out;
  logic [7:0] a_data, b_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic       m_dual = 0, m_par = 0, m_af = 0, m_odd = 0;
  logic [7:0] m_hold = '0;
  logic [7:0] ea = '0, eb = '0;
  logic       eva = 0, evb = 0, edclk = 0;

  always #2 clk = ~clk;

  pix_dual_port_fmt dut (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_parallel(cfg_parallel),
    .cfg_a_first(cfg_a_first), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sol(in_sol), .a_data(a_data), .a_valid(a_valid),
    .b_data(b_data), .b_valid(b_valid), .dclk_out(dclk_out)
  );

  function automatic string pick_tag(input logic v, input logic s);
    if (!v) return "R8";
    if (s) return "R4";
    if (!m_dual) return "R2";
    return m_par ? "R5" : "R3";
  endfunction

  task automatic model_beat(input logic v, input logic s, input logic [7:0] d);
    logic odd;
    eva = 0;
    evb = 0;
    if (!v) return;
    if (s) begin
      m_dual = cfg_dual; m_par = cfg_parallel; m_af = cfg_a_first;
    end
    odd   = s ? 1'b0 : m_odd;
    m_odd = !odd;
    if (!m_dual) begin
      ea = d; eva = 1; eb = '0; edclk = 0;
    end else begin
      edclk = !odd;
      if (!m_par) begin
        if ((!odd) == m_af) begin ea = d; eva = 1; end
        else begin eb = d; evb = 1; end
      end else if (!odd) begin
        m_hold = d;
      end else begin
        ea = m_af ? m_hold : d;
        eb = m_af ? d : m_hold;
        eva = 1; evb = 1;
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (a_data !== ea || a_valid !== eva || b_data !== eb || b_valid !== evb) begin
      errors++;
      $display("FAIL %s: got a=%h/%b b=%h/%b expected a=%h/%b b=%h/%b",
               tag, a_data, a_valid, b_data, b_valid, ea, eva, eb, evb);
    end
    checks++;
    if (dclk_out !== edclk || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R7/R10: got dclk=%b ready=%b expected dclk=%b ready=1",
               dclk_out, in_ready, edclk);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [7:0] d,
                      input logic cd, input logic cp, input logic ca, input string tag);
    string t;
    in_valid = v; in_sol = s; in_data = d;
    cfg_dual = cd; cfg_parallel = cp; cfg_a_first = ca;
    @(posedge clk);
    model_beat(v, s, d);
    t = (tag == "") ? pick_tag(v, s) : tag;
    @(negedge clk);
    compare(t);
  endtask

  task automatic line(input int n, input logic cd, input logic cp, input logic ca,
                      input logic [7:0] base);
    for (int i = 0; i < n; i++) step(1, i == 0, base + 8'(i), cd, cp, ca, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    line(4, 0, 0, 0, 8'h10);              // R2 single
    line(5, 1, 0, 1, 8'h20);              // R3/R4 staggered, A first
    line(3, 1, 0, 0, 8'h30);              // R4 staggered, B first
    line(4, 1, 1, 1, 8'h40);              // R5 paired, A first
    line(3, 1, 1, 0, 8'h50);              // R5 paired, odd length
    step(1, 1, 8'h60, 1, 1, 1, "R9");     // leftover byte dropped, no strobe
    step(1, 0, 8'h61, 1, 1, 1, "R9");
    step(1, 1, 8'h70, 1, 0, 1, "R6");     // staggered line, then config churn
    step(1, 0, 8'h71, 0, 1, 0, "R6");
    step(1, 0, 8'h72, 0, 0, 0, "R6");
    step(1, 0, 8'h73, 1, 1, 0, "R6");
    step(0, 0, 8'hEE, 1, 0, 1, "R8");     // gaps hold data and dclk
    step(0, 0, 8'hEF, 1, 0, 1, "R8");
    step(1, 0, 8'h74, 1, 0, 1, "R7");
    step(1, 1, 8'h80, 0, 0, 0, "R2");     // back to single clears port B
    step(1, 0, 8'h81, 0, 0, 0, "R2");

    for (int k = 0; k < 400; k++) begin
      int n;
      logic cd, cp, ca;
      n  = 1 + int'($urandom_range(8));
      cd = 1'($urandom); cp = 1'($urandom); ca = 1'($urandom);
      for (int i = 0; i < n; i++) begin
        while ($urandom_range(3) == 0)
          step(0, 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "");
        if (i == 0) step(1, 1, 8'($urandom), cd, cp, ca, "");
        else step(1, 0, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule